// File: doc/BRIEF.md
# Base-Integer Instruction Decoder

This block turns one 32-bit base-integer instruction word into the control bundle for a single-cycle core. It pulls out the register-file indices and builds a sign-extended immediate. It also produces the operand-source selects for the ALU, the data-memory read and write strobes, the register write strobe and a two-bit write-back source code. The ALU operation itself is chosen elsewhere. The decoder is purely combinational: the word fetched in a cycle is decoded in that same cycle.

It recognises nine major opcodes: register-register, register-immediate, load, store, conditional branch, load-upper-immediate, add-upper-immediate-to-PC, jump-and-link and jump-and-link-register. Every other word decodes as a no-op. A no-op drives all strobes low, both operand selects to 0, the write-back code to 0 and the immediate to 0. This covers fences, system calls and compressed encodings. The immediate is sign-extended to the parameter `XLEN`. A build option, `SUPPRESS_X0_WRITE`, can drop the register write strobe when the destination is register 0.

Top module: `rv_inst_decoder`

## Requirements
- R1: Only words whose low seven bits equal 0000011, 0010011, 0010111, 0100011, 0110011, 0110111, 1100011, 1100111 or 1101111 are recognised. Any other word drives memory read, memory write and register write low, both operand selects 0, write-back code 0 and immediate 0.
- R2: Field extraction is fixed for every word: `rs2_addr_o` = bits 24:20 and `rd_addr_o` = bits 11:7. `rs1_addr_o` = bits 19:15, except as stated in R5.
- R3: Store (low bits 0100011): memory write 1, memory read 0, register write 0, op1 select 0, op2 select 1, S-format immediate (bits 31:25 over 11:7). Word 0x00A02223 gives rs1 0 and immediate 4.
- R4: Load (0000011): memory read 1, register write 1, write-back 1, op1 select 0, op2 select 1, I-format immediate (bits 31:20). Word 0x00092503 gives rs1 18, rd 10 and immediate 0.
- R5: Load-upper-immediate (0110111): `rs1_addr_o` forced to 0, op1 select 0, op2 select 1, register write 1, write-back 0, immediate = bits 31:12 with the low 12 bits zero.
- R6: Add-upper-immediate-to-PC (0010111): op1 select 1, op2 select 1, register write 1, write-back 0, U-format immediate.
- R7: Register-register (0110011): op1 select 0, op2 select 0, register write 1, write-back 0, immediate 0, no memory access.
- R8: Register-immediate (0010011): op1 select 0, op2 select 1, register write 1, write-back 0, I-format immediate.
- R9: Conditional branch (1100011): op1 select 1, op2 select 1, no register write, no memory access, B-format immediate with bit 0 zero.
- R10: Jump-and-link (1101111): op1 select 1, op2 select 1, register write 1, write-back 3, J-format immediate with bit 0 zero.
- R11: Jump-and-link-register (1100111): op1 select 0, op2 select 1, register write 1, write-back 3, I-format immediate.
- R12: Every non-zero immediate is sign-extended from instruction bit 31 up to `XLEN` bits.
- R13: The select encodings are fixed. Op1: 0 = rs1 data, 1 = instruction address. Op2: 0 = rs2 data, 1 = immediate. Write-back: 0 = ALU result, 1 = memory data, 3 = instruction address plus 4. Code 2 is never driven, and memory read and write are never high together.
- R14: With `SUPPRESS_X0_WRITE` = 1, a writing instruction whose rd field is 0 drives register write 0. All other outputs are the same as with the option off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| rs1_addr_o | output | 5 | First source register index |
| rs2_addr_o | output | 5 | Second source register index |
| rd_addr_o | output | 5 | Destination register index |
| imm_o | output | XLEN | Sign-extended immediate |
| op1_sel_o | output | 1 | ALU operand one source: 0 rs1, 1 instruction address |
| op2_sel_o | output | 1 | ALU operand two source: 0 rs2, 1 immediate |
| mem_rd_en_o | output | 1 | Data memory read strobe |
| mem_wr_en_o | output | 1 | Data memory write strobe |
| reg_wr_en_o | output | 1 | Register file write strobe |
| wb_sel_o | output | 2 | Write-back source code |

## Verification
The bench builds two copies side by side. The first uses the defaults (`XLEN` 32, `SUPPRESS_X0_WRITE` 0), which exercises the straight 32-bit immediate path and ungated register writes. The second uses `XLEN` 64 and `SUPPRESS_X0_WRITE` 1, which brings the upper-word sign extension and the register-0 write gating within reach. Both copies see the same directed words and a long run of random words built around every major opcode and several unrecognised ones.

// File: rtl/rv_dec_pkg.sv
package rv_dec_pkg;

   localparam int unsigned INSN_W    = 32;
   localparam int unsigned REG_IDX_W = 5;
   localparam int unsigned WB_SEL_W  = 2;

   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;

   localparam logic OP1_FROM_RS1 = 1'b0;
   localparam logic OP1_FROM_PC  = 1'b1;
   localparam logic OP2_FROM_RS2 = 1'b0;
   localparam logic OP2_FROM_IMM = 1'b1;

   localparam logic [WB_SEL_W-1:0] WB_FROM_ALU  = 2'd0;
   localparam logic [WB_SEL_W-1:0] WB_FROM_MEM  = 2'd1;
   localparam logic [WB_SEL_W-1:0] WB_FROM_LINK = 2'd3;

   typedef enum logic [3:0] {
      CL_NONE,
      CL_LOAD,
      CL_OPIMM,
      CL_AUIPC,
      CL_STORE,
      CL_REG,
      CL_LUI,
      CL_BRANCH,
      CL_JALR,
      CL_JAL
   } op_class_e;

   typedef enum logic [2:0] {
      FMT_NONE,
      FMT_I,
      FMT_S,
      FMT_B,
      FMT_U,
      FMT_J
   } imm_fmt_e;

endpackage

// File: rtl/rv_opclass.sv
module rv_opclass
   import rv_dec_pkg::*;
(
   input  logic [6:0] opcode_i,
   output op_class_e  cls_o,
   output imm_fmt_e   fmt_o
);

   always_comb begin
      cls_o = CL_NONE;
      fmt_o = FMT_NONE;
      unique case (opcode_i)
         OPC_LOAD:   begin cls_o = CL_LOAD;   fmt_o = FMT_I; end
         OPC_OPIMM:  begin cls_o = CL_OPIMM;  fmt_o = FMT_I; end
         OPC_AUIPC:  begin cls_o = CL_AUIPC;  fmt_o = FMT_U; end
         OPC_STORE:  begin cls_o = CL_STORE;  fmt_o = FMT_S; end
         OPC_REG:    begin cls_o = CL_REG;    fmt_o = FMT_NONE; end
         OPC_LUI:    begin cls_o = CL_LUI;    fmt_o = FMT_U; end
         OPC_BRANCH: begin cls_o = CL_BRANCH; fmt_o = FMT_B; end
         OPC_JALR:   begin cls_o = CL_JALR;   fmt_o = FMT_I; end
         OPC_JAL:    begin cls_o = CL_JAL;    fmt_o = FMT_J; end
         default:    begin cls_o = CL_NONE;   fmt_o = FMT_NONE; end
      endcase
   end

   // R1
   always_comb begin
      fmt_none_class_chk: assert ((fmt_o == FMT_NONE) == (cls_o == CL_NONE || cls_o == CL_REG))
         else $error("immediate format disagrees with class");
   end

endmodule

// File: rtl/rv_immgen.sv
module rv_immgen
   import rv_dec_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [INSN_W-1:7] fld_i,
   input  imm_fmt_e          fmt_i,
   output logic [XLEN-1:0]   imm_o
);

   localparam int unsigned EXT_W = (XLEN > INSN_W) ? (XLEN - INSN_W) : 1;

   if (XLEN < INSN_W) begin : g_bad_xlen
      $error("rv_immgen: XLEN must be at least 32");
   end

   logic [INSN_W-1:0] raw;
   logic              sgn;

   assign sgn = fld_i[31];

   always_comb begin
      unique case (fmt_i)
         FMT_I:   raw = {{20{sgn}}, fld_i[31:20]};
         FMT_S:   raw = {{20{sgn}}, fld_i[31:25], fld_i[11:7]};
         FMT_B:   raw = {{19{sgn}}, sgn, fld_i[7], fld_i[30:25], fld_i[11:8], 1'b0};
         FMT_U:   raw = {fld_i[31:12], 12'b0};
         FMT_J:   raw = {{11{sgn}}, sgn, fld_i[19:12], fld_i[20], fld_i[30:21], 1'b0};
         default: raw = '0;
      endcase
   end

   if (XLEN == INSN_W) begin : g_native
      assign imm_o = raw;
   end else begin : g_extend
      logic [EXT_W-1:0] upper;
      assign upper = {EXT_W{raw[INSN_W-1]}};
      assign imm_o = {upper, raw};

      // R12
      always_comb begin
         upper_sign_chk: assert (imm_o[XLEN-1:INSN_W] == {EXT_W{imm_o[INSN_W-1]}})
            else $error("upper immediate bits not a sign copy");
      end
   end

   // R5
   always_comb begin
      upper_low_zero_chk: assert (fmt_i != FMT_U || imm_o[11:0] == 12'd0)
         else $error("U immediate has non-zero low bits");
   end

   // R9
   always_comb begin
      branch_even_chk: assert (!(fmt_i == FMT_B || fmt_i == FMT_J) || !imm_o[0])
         else $error("jump or branch offset is odd");
   end

   // R7
   always_comb begin
      no_fmt_zero_chk: assert (fmt_i != FMT_NONE || imm_o == '0)
         else $error("immediate not zero without a format");
   end

endmodule

// File: rtl/rv_ctrlgen.sv
module rv_ctrlgen
   import rv_dec_pkg::*;
#(
   parameter bit SUPPRESS_X0_WRITE = 1'b0
) (
   input  op_class_e             cls_i,
   input  logic                  rd_zero_i,
   output logic                  op1_sel_o,
   output logic                  op2_sel_o,
   output logic                  mem_rd_en_o,
   output logic                  mem_wr_en_o,
   output logic                  reg_wr_en_o,
   output logic [WB_SEL_W-1:0]   wb_sel_o
);

   logic writes_rd;

   always_comb begin
      op1_sel_o   = OP1_FROM_RS1;
      op2_sel_o   = OP2_FROM_RS2;
      mem_rd_en_o = 1'b0;
      mem_wr_en_o = 1'b0;
      writes_rd   = 1'b0;
      wb_sel_o    = WB_FROM_ALU;
      unique case (cls_i)
         CL_LOAD: begin
            op2_sel_o   = OP2_FROM_IMM;
            mem_rd_en_o = 1'b1;
            writes_rd   = 1'b1;
            wb_sel_o    = WB_FROM_MEM;
         end
         CL_OPIMM: begin
            op2_sel_o = OP2_FROM_IMM;
            writes_rd = 1'b1;
         end
         CL_AUIPC: begin
            op1_sel_o = OP1_FROM_PC;
            op2_sel_o = OP2_FROM_IMM;
            writes_rd = 1'b1;
         end
         CL_STORE: begin
            op2_sel_o   = OP2_FROM_IMM;
            mem_wr_en_o = 1'b1;
         end
         CL_REG: begin
            writes_rd = 1'b1;
         end
         CL_LUI: begin
            op2_sel_o = OP2_FROM_IMM;
            writes_rd = 1'b1;
         end
         CL_BRANCH: begin
            op1_sel_o = OP1_FROM_PC;
            op2_sel_o = OP2_FROM_IMM;
         end
         CL_JALR: begin
            op2_sel_o = OP2_FROM_IMM;
            writes_rd = 1'b1;
            wb_sel_o  = WB_FROM_LINK;
         end
         CL_JAL: begin
            op1_sel_o = OP1_FROM_PC;
            op2_sel_o = OP2_FROM_IMM;
            writes_rd = 1'b1;
            wb_sel_o  = WB_FROM_LINK;
         end
         default: begin
            op1_sel_o = OP1_FROM_RS1;
         end
      endcase
   end

   if (SUPPRESS_X0_WRITE) begin : g_gate_x0
      assign reg_wr_en_o = writes_rd & ~rd_zero_i;
   end else begin : g_plain
      assign reg_wr_en_o = writes_rd;
   end

   // R13
   always_comb begin
      mem_excl_chk: assert (!(mem_rd_en_o && mem_wr_en_o))
         else $error("memory read and write together");
   end

   // R13
   always_comb begin
      wb_code_chk: assert (wb_sel_o != 2'd2)
         else $error("reserved write-back code driven");
   end

   // R3
   always_comb begin
      store_no_wb_chk: assert (!mem_wr_en_o || !reg_wr_en_o)
         else $error("store also writes a register");
   end

   // R14
   always_comb begin
      x0_gate_chk: assert (!(SUPPRESS_X0_WRITE && rd_zero_i && reg_wr_en_o))
         else $error("write to register 0 not suppressed");
   end

   // R4
   always_comb begin
      mem_data_wb_chk: assert (wb_sel_o != WB_FROM_MEM || mem_rd_en_o)
         else $error("memory write-back without a read");
   end

endmodule

// File: rtl/rv_inst_decoder.sv
module rv_inst_decoder
   import rv_dec_pkg::*;
#(
   parameter int unsigned XLEN              = 32,
   parameter bit          SUPPRESS_X0_WRITE = 1'b0
) (
   input  logic [31:0]       instr_i,
   output logic [4:0]        rs1_addr_o,
   output logic [4:0]        rs2_addr_o,
   output logic [4:0]        rd_addr_o,
   output logic [XLEN-1:0]   imm_o,
   output logic              op1_sel_o,
   output logic              op2_sel_o,
   output logic              mem_rd_en_o,
   output logic              mem_wr_en_o,
   output logic              reg_wr_en_o,
   output logic [1:0]        wb_sel_o
);

   if (XLEN < INSN_W) begin : g_bad_xlen
      $error("rv_inst_decoder: XLEN must be at least 32");
   end

   op_class_e cls;
   imm_fmt_e  fmt;

   rv_opclass u_opclass (
      .opcode_i (instr_i[6:0]),
      .cls_o    (cls),
      .fmt_o    (fmt)
   );

   rv_immgen #(
      .XLEN (XLEN)
   ) u_immgen (
      .fld_i (instr_i[INSN_W-1:7]),
      .fmt_i (fmt),
      .imm_o (imm_o)
   );

   rv_ctrlgen #(
      .SUPPRESS_X0_WRITE (SUPPRESS_X0_WRITE)
   ) u_ctrlgen (
      .cls_i       (cls),
      .rd_zero_i   (instr_i[11:7] == '0),
      .op1_sel_o   (op1_sel_o),
      .op2_sel_o   (op2_sel_o),
      .mem_rd_en_o (mem_rd_en_o),
      .mem_wr_en_o (mem_wr_en_o),
      .reg_wr_en_o (reg_wr_en_o),
      .wb_sel_o    (wb_sel_o)
   );

   assign rs1_addr_o = (cls == CL_LUI) ? '0 : instr_i[19:15];
   assign rs2_addr_o = instr_i[24:20];
   assign rd_addr_o  = instr_i[11:7];

   // R5
   always_comb begin
      lui_x0_src_chk: assert (instr_i[6:0] != OPC_LUI || rs1_addr_o == '0)
         else $error("upper-immediate load reads a non-zero register");
   end

   // R1
   always_comb begin
      unknown_quiet_chk: assert (!(instr_i[1:0] != 2'b11 &&
                                   (mem_rd_en_o || mem_wr_en_o || reg_wr_en_o)))
         else $error("unrecognised word raised a strobe");
   end

   // R10
   always_comb begin
      link_writes_chk: assert (wb_sel_o != WB_FROM_LINK || op2_sel_o == OP2_FROM_IMM)
         else $error("link write-back without immediate operand");
   end

endmodule

// File: tb/rv_inst_decoder_bench.sv
`timescale 1ns/1ps
module rv_inst_decoder_bench;

   localparam int unsigned W_NARROW = 32;
   localparam int unsigned W_WIDE   = 64;

   typedef struct packed {
      logic [4:0]  rs1;
      logic [4:0]  rs2;
      logic [4:0]  rd;
      logic [63:0] imm;
      logic        op1;
      logic        op2;
      logic        mrd;
      logic        mwr;
      logic        we;
      logic [1:0]  wb;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [31:0] instr = 32'h0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   logic [4:0] a_rs1, a_rs2, a_rd, b_rs1, b_rs2, b_rd;
   logic [W_NARROW-1:0] a_imm;
   logic [W_WIDE-1:0]   b_imm;
   logic a_op1, a_op2, a_mrd, a_mwr, a_we, b_op1, b_op2, b_mrd, b_mwr, b_we;
   logic [1:0] a_wb, b_wb;

   rv_inst_decoder u_rv_inst_decoder (
      .instr_i (instr), .rs1_addr_o (a_rs1), .rs2_addr_o (a_rs2), .rd_addr_o (a_rd),
      .imm_o (a_imm), .op1_sel_o (a_op1), .op2_sel_o (a_op2), .mem_rd_en_o (a_mrd),
      .mem_wr_en_o (a_mwr), .reg_wr_en_o (a_we), .wb_sel_o (a_wb)
   );

   rv_inst_decoder #(.XLEN (W_WIDE), .SUPPRESS_X0_WRITE (1'b1)) u_rv_inst_decoder_wide (
      .instr_i (instr), .rs1_addr_o (b_rs1), .rs2_addr_o (b_rs2), .rd_addr_o (b_rd),
      .imm_o (b_imm), .op1_sel_o (b_op1), .op2_sel_o (b_op2), .mem_rd_en_o (b_mrd),
      .mem_wr_en_o (b_mwr), .reg_wr_en_o (b_we), .wb_sel_o (b_wb)
   );

   function automatic exp_t ref_model(input logic [31:0] w, input bit gate0, output string tag);
      exp_t e;
      longint v;
      e = '0;
      v = 0;
      tag = "R1";
      e.rs1 = w[19:15];
      e.rs2 = w[24:20];
      e.rd  = w[11:7];
      case (w[6:0])
         7'b0000011: begin tag = "R4"; e.op2 = 1; e.mrd = 1; e.we = 1; e.wb = 1;
                           v = longint'($signed(w[31:20])); end
         7'b0010011: begin tag = "R8"; e.op2 = 1; e.we = 1;
                           v = longint'($signed(w[31:20])); end
         7'b0010111: begin tag = "R6"; e.op1 = 1; e.op2 = 1; e.we = 1;
                           v = longint'($signed({w[31:12], 12'h000})); end
         7'b0100011: begin tag = "R3"; e.op2 = 1; e.mwr = 1;
                           v = longint'($signed({w[31:25], w[11:7]})); end
         7'b0110011: begin tag = "R7"; e.we = 1; end
         7'b0110111: begin tag = "R5"; e.op2 = 1; e.we = 1; e.rs1 = 0;
                           v = longint'($signed({w[31:12], 12'h000})); end
         7'b1100011: begin tag = "R9"; e.op1 = 1; e.op2 = 1;
                           v = longint'($signed({w[31], w[7], w[30:25], w[11:8], 1'b0})); end
         7'b1100111: begin tag = "R11"; e.op2 = 1; e.we = 1; e.wb = 3;
                           v = longint'($signed(w[31:20])); end
         7'b1101111: begin tag = "R10"; e.op1 = 1; e.op2 = 1; e.we = 1; e.wb = 3;
                           v = longint'($signed({w[31], w[19:12], w[20], w[30:21], 1'b0})); end
         default: tag = "R1";
      endcase
      if (gate0 && e.rd == 5'd0) e.we = 0;
      e.imm = 64'(v);
      return e;
   endfunction

   task automatic note(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s instr=%h actual=%h expected=%h", tag, what, instr, act, exp);
      end
   endtask

   task automatic compare_now();
      exp_t ea, eb;
      string t;
      string tw;
      ea = ref_model(instr, 1'b0, t);
      eb = ref_model(instr, 1'b1, t);
      // R2 fields (R5 for the forced source index)
      note(a_rs1 == ea.rs1, (instr[6:0] == 7'b0110111) ? "R5" : "R2", "rs1", 64'(a_rs1), 64'(ea.rs1));
      note({a_rs2, a_rd} == {ea.rs2, ea.rd}, "R2", "rs2/rd", 64'({a_rs2, a_rd}), 64'({ea.rs2, ea.rd}));
      note(a_imm == ea.imm[31:0], t, "imm32", 64'(a_imm), 64'(ea.imm[31:0]));
      note({a_op1, a_op2, a_mrd, a_mwr, a_we, a_wb} == {ea.op1, ea.op2, ea.mrd, ea.mwr, ea.we, ea.wb},
           t, "ctrl", 64'({a_op1, a_op2, a_mrd, a_mwr, a_we, a_wb}),
           64'({ea.op1, ea.op2, ea.mrd, ea.mwr, ea.we, ea.wb}));
      // R13 reserved code and exclusive strobes
      note(a_wb != 2'd2 && !(a_mrd && a_mwr) && b_wb != 2'd2, "R13", "codes",
           64'({a_wb, a_mrd, a_mwr}), 64'(0));
      // R12 sign extension at 64 bits
      note(b_imm == eb.imm, "R12", "imm64", b_imm, eb.imm);
      tw = (instr[11:7] == 5'd0) ? "R14" : t;
      note(b_we == eb.we, tw, "we64", 64'(b_we), 64'(eb.we));
      note({b_rs1, b_rs2, b_rd, b_op1, b_op2, b_mrd, b_mwr, b_wb} ==
           {eb.rs1, eb.rs2, eb.rd, eb.op1, eb.op2, eb.mrd, eb.mwr, eb.wb}, "R14", "rest64",
           64'({b_rs1, b_rs2, b_rd, b_op1, b_op2, b_mrd, b_mwr, b_wb}),
           64'({eb.rs1, eb.rs2, eb.rd, eb.op1, eb.op2, eb.mrd, eb.mwr, eb.wb}));
   endtask

   task automatic apply(input logic [31:0] w);
      @(posedge clk);
      instr <= w;
      @(negedge clk);
      compare_now();
   endtask

   logic [31:0] directed [18] = '{
      32'h00A02223, 32'h00092503, 32'h123450B7, 32'h003100B3, 32'h00940463,
      32'hFE208EE3, 32'hFF9FF06F, 32'h008000EF, 32'h000080E7, 32'hFFFFF517,
      32'hFFF00093, 32'hFE112E23, 32'h0000000F, 32'h00000073, 32'h00004501,
      32'hFFFFFFFF, 32'h00000033, 32'h80000037
   };

   logic [6:0] opc_pool [12] = '{
      7'b0000011, 7'b0010011, 7'b0010111, 7'b0100011, 7'b0110011, 7'b0110111,
      7'b1100011, 7'b1100111, 7'b1101111, 7'b0001111, 7'b1110011, 7'b1101011
   };

   initial begin
      repeat (3) @(posedge clk);
      rst <= 1'b0;
      @(negedge clk);
      // R1 quiet outputs for an all-zero word after reset
      note({a_mrd, a_mwr, a_we, a_op1, a_op2, a_wb} == 7'd0 && a_imm == 32'd0, "R1", "reset",
           64'({a_mrd, a_mwr, a_we, a_op1, a_op2, a_wb}), 64'(0));
      // R3 literal example
      apply(32'h00A02223);
      note(a_rs1 == 5'd0 && a_imm == 32'd4 && a_mwr && !a_we, "R3", "store example",
           64'({a_rs1, a_imm}), 64'({5'd0, 32'd4}));
      // R4 literal example
      apply(32'h00092503);
      note(a_rs1 == 5'd18 && a_rd == 5'd10 && a_imm == 32'd0 && a_mrd && a_wb == 2'd1,
           "R4", "load example", 64'({a_rs1, a_rd, a_wb}), 64'({5'd18, 5'd10, 2'd1}));
      // R10 negative jump offset reaches both widths
      apply(32'hFF9FF06F);
      note(a_imm == 32'hFFFFFFF8 && b_imm == 64'hFFFFFFFFFFFFFFF8 && !b_we && a_we,
           "R10", "jal -8", 64'(a_imm), 64'hFFFFFFF8);
      foreach (directed[i]) apply(directed[i]);
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] w;
         w = $urandom();
         if (k % 8 != 7) w[6:0] = opc_pool[$urandom_range(0, 11)];
         if (k % 5 == 0) w[11:7] = 5'd0;
         apply(w);
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule